// File: doc/BRIEF.md
# Four-Channel Memory Transfer Engine

This block copies or fills memory without processor involvement. Four independent channels are each programmed through three 32-bit registers: a source address, a destination address and a control word. The control word holds the unit count and the mode bits. After its enable bit is set, a channel moves 16-bit or 32-bit units over one master memory port. It does this either at once or when a vertical-blank, horizontal-blank or display-sync pulse arrives.

The source and destination addresses step independently: up, down or held. A held source gives a fill, which writes one value to every destination. A blank-triggered channel with repeat set stays armed after each burst and reloads its count. In the reload destination mode it also returns the destination to its programmed start. Channel 0 has the highest priority. Arbitration happens between units, so a higher channel can take the port in the middle of a lower channel's burst.

Top module: `dma4_engine`

## Requirements
- R1: Channel n owns byte offsets 12n (source), 12n+4 (destination) and 12n+8 (control). A write sets the register, and a read on the same offset returns it. The control read shows the live enable bit and the low CNT_W count bits.
- R2: A 0-to-1 change of control bit 31 copies the source and destination registers into the channel's working addresses. With trigger field 29:28 = 0 the transfer then starts with no further event. After reset no memory access and no interrupt take place.
- R3: Each unit is a read cycle (mem_re) followed directly by a write cycle (mem_we). The write carries the data read in the previous cycle. mem_wide equals control bit 26 (0 = halfword, 1 = word).
- R4: The source address moves by 2 (halfword) or 4 (word) after each unit. Bits 24:23 give the direction: 0 = up, 1 = down, 2 = held.
- R5: The destination address follows bits 22:21 in the same way: 0 = up, 1 = down, 2 = held, 3 = up with reload.
- R6: The count field occupies the low CNT_W bits of the control word, and a count of 0 moves 2^CNT_W units.
- R7: Trigger values 1, 2 and 3 make an enabled channel wait for a vblank, hblank or dsync pulse respectively. Pulses of the other two kinds do not start it.
- R8: At the end of a burst without repeat the channel clears its enable bit. If control bit 30 is set, irq[n] is high for exactly one cycle, in the cycle after the last write.
- R9: With bit 25 set and a blank-type trigger, the channel keeps its enable bit and reloads the count, then waits for the next pulse. Destination mode 3 restarts at the programmed destination; the other modes continue from where they stopped.
- R10: When several channels are pending, the lowest-numbered one gets the next unit. A newly pending higher-priority channel takes the port after the unit in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| vblank | input | 1 | Vertical-blank start pulse |
| hblank | input | 1 | Horizontal-blank start pulse |
| dsync | input | 1 | Display-sync pulse |
| mem_re | output | 1 | Memory read cycle |
| mem_we | output | 1 | Memory write cycle |
| mem_wide | output | 1 | Unit size, 1 = 32-bit |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the read cycle |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench sweeps every pairing of source mode, destination mode and unit size. A design that used the wrong step or direction would put its write addresses off the computed sequence. A count of zero must move a full 16 units in the small bench configuration; a design that took zero literally would move nothing. Repeat bursts are run with and without destination reload, which exposes a design that forgets to restore the start address or that restores it when it should not. Trigger sorting and priority are checked by firing the wrong blank pulses and by enabling a higher channel during a lower one's burst. A design with inverted or per-burst priority writes to the regions in the wrong order.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int WORD_W    = 32;
    localparam int EN_BIT    = 31;
    localparam int IRQ_BIT   = 30;
    localparam int TRIG_LO   = 28;
    localparam int WIDE_BIT  = 26;
    localparam int RPT_BIT   = 25;
    localparam int SRC_LO    = 23;
    localparam int DST_LO    = 21;
    localparam int REG_STRIDE = 12;

    typedef enum logic [1:0] {TRIG_NOW, TRIG_VBL, TRIG_HBL, TRIG_SYNC} trig_e;
    typedef enum logic [1:0] {STEP_UP, STEP_DOWN, STEP_HOLD, STEP_UP_RELOAD} step_e;
    typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

    typedef struct packed {
        logic  en;
        logic  irq_en;
        trig_e trig;
        logic  wide;
        logic  rpt;
        step_e src_step;
        step_e dst_step;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en       = w[EN_BIT];
        c.irq_en   = w[IRQ_BIT];
        c.trig     = trig_e'(w[TRIG_LO+1:TRIG_LO]);
        c.wide     = w[WIDE_BIT];
        c.rpt      = w[RPT_BIT];
        c.src_step = step_e'(w[SRC_LO+1:SRC_LO]);
        c.dst_step = step_e'(w[DST_LO+1:DST_LO]);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_BIT]              = c.en;
        w[IRQ_BIT]             = c.irq_en;
        w[TRIG_LO+1:TRIG_LO]   = c.trig;
        w[WIDE_BIT]            = c.wide;
        w[RPT_BIT]             = c.rpt;
        w[SRC_LO+1:SRC_LO]     = c.src_step;
        w[DST_LO+1:DST_LO]     = c.dst_step;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                    input step_e m, input logic wide);
        logic [WORD_W-1:0] d;
        d = wide ? WORD_W'(4) : WORD_W'(2);
        case (m)
            STEP_UP, STEP_UP_RELOAD: return a + d;
            STEP_DOWN:               return a - d;
            default:                 return a;
        endcase
    endfunction

endpackage

// File: rtl/dma4_channel.sv
module dma4_channel
    import dma4_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_src,
    input  logic              wr_dst,
    input  logic              wr_ctrl,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ev_vbl,
    input  logic              ev_hbl,
    input  logic              ev_sync,
    input  logic              unit_done,
    output logic              req,
    output logic              wide,
    output logic [WORD_W-1:0] cur_src,
    output logic [WORD_W-1:0] cur_dst,
    output logic [WORD_W-1:0] src_reg,
    output logic [WORD_W-1:0] dst_reg,
    output logic [WORD_W-1:0] ctrl_rd,
    output logic              irq
);

    localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

    ctrl_t            ctl_q, ctl_new;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   left_q;
    logic             pend_q;
    logic             fire;
    step_e            src_mode;

    function automatic logic [CNT_W:0] load_cnt(input logic [CNT_W-1:0] c);
        return (c == '0) ? FULL_CNT : {1'b0, c};
    endfunction

    assign ctl_new  = unpack_ctrl(wdata);
    assign src_mode = (ctl_q.src_step == STEP_UP_RELOAD) ? STEP_HOLD : ctl_q.src_step;

    always_comb begin
        case (ctl_q.trig)
            TRIG_VBL:  fire = ev_vbl;
            TRIG_HBL:  fire = ev_hbl;
            TRIG_SYNC: fire = ev_sync;
            default:   fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            cnt_q   <= '0;
            left_q  <= '0;
            pend_q  <= 1'b0;
            src_reg <= '0;
            dst_reg <= '0;
            cur_src <= '0;
            cur_dst <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_src) src_reg <= wdata;
            if (wr_dst) dst_reg <= wdata;
            if (wr_ctrl) begin
                ctl_q <= ctl_new;
                cnt_q <= wdata[CNT_W-1:0];
                if (ctl_new.en && !ctl_q.en) begin
                    cur_src <= src_reg;
                    cur_dst <= dst_reg;
                    left_q  <= load_cnt(wdata[CNT_W-1:0]);
                    pend_q  <= (ctl_new.trig == TRIG_NOW);
                end else if (!ctl_new.en) begin
                    pend_q  <= 1'b0;
                end
            end else if (ctl_q.en) begin
                if (!pend_q && fire) begin
                    pend_q <= 1'b1;
                end
                if (pend_q && unit_done) begin
                    cur_src <= step_addr(cur_src, src_mode, ctl_q.wide);
                    cur_dst <= step_addr(cur_dst, ctl_q.dst_step, ctl_q.wide);
                    left_q  <= left_q - 1'b1;
                    if (left_q == {{CNT_W{1'b0}}, 1'b1}) begin
                        pend_q <= 1'b0;
                        irq    <= ctl_q.irq_en;
                        if (ctl_q.rpt && ctl_q.trig != TRIG_NOW) begin
                            left_q <= load_cnt(cnt_q);
                            if (ctl_q.dst_step == STEP_UP_RELOAD) cur_dst <= dst_reg;
                        end else begin
                            ctl_q.en <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign req     = ctl_q.en && pend_q;
    assign wide    = ctl_q.wide;
    assign ctrl_rd = pack_ctrl(ctl_q) | WORD_W'(cnt_q);

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] gnt
);

    always_comb begin
        gnt = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (req[c]) gnt = NUM_CH'(1) << c;
        end
    end

endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] gnt,
    input  logic [WORD_W-1:0] src_a [NUM_CH],
    input  logic [WORD_W-1:0] dst_a [NUM_CH],
    input  logic [NUM_CH-1:0] wide_a,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [NUM_CH-1:0] unit_done
);

    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    mv_state_e         st_q;
    logic [NUM_CH-1:0] sel_q;
    logic [IW-1:0]     idx_q, idx_d;
    logic [WORD_W-1:0] data_q;

    always_comb begin
        idx_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (gnt[c]) idx_d = IW'(c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= MV_IDLE;
            sel_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                MV_IDLE: if (|req) begin
                    sel_q <= gnt;
                    idx_q <= idx_d;
                    st_q  <= MV_READ;
                end
                MV_READ: begin
                    data_q <= mem_rdata;
                    st_q   <= MV_WRITE;
                end
                default: st_q <= MV_IDLE;
            endcase
        end
    end

    assign mem_re    = (st_q == MV_READ);
    assign mem_we    = (st_q == MV_WRITE);
    assign mem_addr  = mem_re ? src_a[idx_q] : (mem_we ? dst_a[idx_q] : '0);
    assign mem_wide  = (mem_re || mem_we) && wide_a[idx_q];
    assign mem_wdata = mem_we ? data_q : '0;
    assign unit_done = mem_we ? sel_q : '0;

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(NUM_CH * REG_STRIDE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              vblank,
    input  logic              hblank,
    input  logic              dsync,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0] req, gnt, unit_done, wide_a;
    logic [WORD_W-1:0] src_a  [NUM_CH];
    logic [WORD_W-1:0] dst_a  [NUM_CH];
    logic [WORD_W-1:0] srcr_a [NUM_CH];
    logic [WORD_W-1:0] dstr_a [NUM_CH];
    logic [WORD_W-1:0] ctlr_a [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = g * REG_STRIDE;
        logic w_s, w_d, w_c;
        assign w_s = reg_wr && (reg_addr == AW'(BASE));
        assign w_d = reg_wr && (reg_addr == AW'(BASE + 4));
        assign w_c = reg_wr && (reg_addr == AW'(BASE + 8));

        dma4_channel #(.CNT_W(CNT_W)) ch_i (
            .clk      (clk),
            .rst      (rst),
            .wr_src   (w_s),
            .wr_dst   (w_d),
            .wr_ctrl  (w_c),
            .wdata    (reg_wdata),
            .ev_vbl   (vblank),
            .ev_hbl   (hblank),
            .ev_sync  (dsync),
            .unit_done(unit_done[g]),
            .req      (req[g]),
            .wide     (wide_a[g]),
            .cur_src  (src_a[g]),
            .cur_dst  (dst_a[g]),
            .src_reg  (srcr_a[g]),
            .dst_reg  (dstr_a[g]),
            .ctrl_rd  (ctlr_a[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == AW'(c * REG_STRIDE))     reg_rdata = srcr_a[c];
            if (reg_addr == AW'(c * REG_STRIDE + 4)) reg_rdata = dstr_a[c];
            if (reg_addr == AW'(c * REG_STRIDE + 8)) reg_rdata = ctlr_a[c];
        end
    end

    dma4_prio #(.NUM_CH(NUM_CH)) prio_i (
        .req(req),
        .gnt(gnt)
    );

    dma4_mover #(.NUM_CH(NUM_CH)) mover_i (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .gnt      (gnt),
        .src_a    (src_a),
        .dst_a    (dst_a),
        .wide_a   (wide_a),
        .mem_rdata(mem_rdata),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .mem_wide (mem_wide),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .unit_done(unit_done)
    );

endmodule

// File: rtl/dma4_checker.sv
module dma4_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_re,
    input logic              mem_we,
    input logic [31:0]       mem_rdata,
    input logic [31:0]       mem_wdata,
    input logic [NUM_CH-1:0] irq
);

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst) mem_re |=> mem_we);
    // R3
    wr_needs_rd_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> $past(mem_re));
    // R3
    wdata_match_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == $past(mem_rdata)));
    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(mem_re && mem_we));
    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(irq));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) (|irq) |=> !(|irq));
    // R8
    irq_after_wr_chk: assert property (@(posedge clk) disable iff (rst) (|irq) |-> $past(mem_we));

endmodule

bind dma4_engine dma4_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata),
    .irq      (irq)
);

// File: tb/dma4_engine_tb_top.sv
module dma4_engine_tb_top;

    localparam int NCH = 4;
    localparam int CW  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        vblank = 1'b0, hblank = 1'b0, dsync = 1'b0;
    logic        mem_re, mem_we, mem_wide;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [NCH-1:0] irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] rd_log [64];
    logic [31:0] wa_log [64];
    logic [31:0] wd_log [64];
    logic        wide_log [64];
    int rd_n = 0, wr_n = 0;
    int irq_cnt [NCH];

    always #10 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h3C5A};
    endfunction

    assign mem_rdata = mem_re ? pat(mem_addr) : 32'h0;

    dma4_engine #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vblank(vblank), .hblank(hblank), .dsync(dsync),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_re && rd_n < 64) begin rd_log[rd_n] = mem_addr; rd_n++; end
            if (mem_we && wr_n < 64) begin
                wa_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata;
                wide_log[wr_n] = mem_wide; wr_n++;
            end
            for (int c = 0; c < NCH; c++) if (irq[c]) irq_cnt[c]++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    function automatic logic [5:0] ra(input int ch, input int k);
        return 6'(ch * 12 + k * 4);
    endfunction

    function automatic logic [31:0] mk(input bit en, input bit ie, input int trig,
                                       input bit wide, input bit rpt, input int sm,
                                       input int dm, input int cnt);
        logic [31:0] w;
        w = '0;
        w[31] = en; w[30] = ie; w[29:28] = 2'(trig); w[26] = wide; w[25] = rpt;
        w[24:23] = 2'(sm); w[22:21] = 2'(dm); w[15:0] = 16'(cnt);
        return w;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input int m,
                                             input bit wide, input int i);
        logic [31:0] st;
        st = wide ? 32'd4 : 32'd2;
        if (m == 1) return b - st * 32'(i);
        if (m == 2) return b;
        return b + st * 32'(i);
    endfunction

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic clr();
        rd_n = 0; wr_n = 0;
        for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;
    endtask

    task automatic wait_wr(input int n);
        int t;
        t = 0;
        while (wr_n < n && t < 3000) begin @(negedge clk); t++; end
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        vblank = (which == 1); hblank = (which == 2); dsync = (which == 3);
        @(negedge clk);
        vblank = 1'b0; hblank = 1'b0; dsync = 1'b0;
    endtask

    task automatic verify(input int off, input int n, input logic [31:0] s, input int sm,
                          input int si, input logic [31:0] d, input int dm, input int di,
                          input bit wide, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [31:0] es, ed;
            es = exp_addr(s, sm, wide, si + i);
            ed = exp_addr(d, dm, wide, di + i);
            chk(rd_log[off+i] == es, {"R4 source address ", tag}, rd_log[off+i], es);
            chk(wa_log[off+i] == ed, {"R5 destination address ", tag}, wa_log[off+i], ed);
            chk(wd_log[off+i] == pat(es), {"R3 write data ", tag}, wd_log[off+i], pat(es));
            chk(wide_log[off+i] == wide, {"R3 unit size ", tag}, 32'(wide_log[off+i]), 32'(wide));
        end
    endtask

    initial begin
        logic [31:0] r;
        int idx;
        for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;
        repeat (4) @(negedge clk);
        // R2: reset state
        chk(!mem_re && !mem_we, "R2 idle after reset", {30'd0, mem_re, mem_we}, 32'd0);
        chk(irq == '0, "R2 no irq after reset", 32'(irq), 32'd0);
        rst = 1'b0;
        rd_reg(ra(0, 2), r);
        chk(r == 32'd0, "R1 control reset value", r, 32'd0);

        // R1: register map readback
        wr_reg(ra(3, 0), 32'h1234_5678);
        wr_reg(ra(3, 1), 32'h9ABC_DEF0);
        wr_reg(ra(3, 2), mk(0, 1, 2, 1, 1, 1, 3, 5));
        rd_reg(ra(3, 0), r); chk(r == 32'h1234_5678, "R1 source readback", r, 32'h1234_5678);
        rd_reg(ra(3, 1), r); chk(r == 32'h9ABC_DEF0, "R1 dest readback", r, 32'h9ABC_DEF0);
        rd_reg(ra(3, 2), r);
        chk(r == mk(0, 1, 2, 1, 1, 1, 3, 5), "R1 control readback", r, mk(0, 1, 2, 1, 1, 1, 3, 5));
        rd_reg(ra(2, 0), r); chk(r == 32'd0, "R1 other channel untouched", r, 32'd0);
        wr_reg(ra(3, 2), 32'd0);

        // R3 R4 R5 R8: sweep of step modes and sizes
        idx = 0;
        for (int sm = 0; sm < 3; sm++)
            for (int dm = 0; dm < 3; dm++)
                for (int w = 0; w < 2; w++) begin
                    int ch;
                    bit ie;
                    logic [31:0] s, d;
                    ch = idx % NCH; ie = idx[0];
                    s = 32'h0000_4000 + 32'(idx * 256);
                    d = 32'h0008_0000 + 32'(idx * 256);
                    clr();
                    wr_reg(ra(ch, 0), s);
                    wr_reg(ra(ch, 1), d);
                    wr_reg(ra(ch, 2), mk(1, ie, 0, w[0], 0, sm, dm, 3));
                    wait_wr(3);
                    chk(wr_n == 3, "R2 immediate start unit count", 32'(wr_n), 32'd3);
                    verify(0, 3, s, sm, 0, d, dm, 0, w[0], "sweep");
                    rd_reg(ra(ch, 2), r);
                    chk(r[31] == 1'b0, "R8 enable cleared", 32'(r[31]), 32'd0);
                    chk(irq_cnt[ch] == 32'(ie), "R8 irq pulse count", 32'(irq_cnt[ch]), 32'(ie));
                    idx++;
                end

        // R6: count zero moves full range
        clr();
        wr_reg(ra(0, 0), 32'h0000_1000);
        wr_reg(ra(0, 1), 32'h0000_2000);
        wr_reg(ra(0, 2), mk(1, 0, 0, 1, 0, 0, 0, 0));
        wait_wr(16);
        chk(wr_n == 16, "R6 zero count means full", 32'(wr_n), 32'd16);
        verify(0, 16, 32'h1000, 0, 0, 32'h2000, 0, 0, 1'b1, "R6");

        // R7: each trigger type only reacts to its own pulse
        for (int t = 1; t <= 3; t++) begin
            clr();
            wr_reg(ra(2, 0), 32'h0000_3000);
            wr_reg(ra(2, 1), 32'h0000_5000);
            wr_reg(ra(2, 2), mk(1, 1, t, 0, 0, 0, 0, 2));
            repeat (10) @(negedge clk);
            chk(wr_n == 0, "R7 waits for trigger", 32'(wr_n), 32'd0);
            for (int o = 1; o <= 3; o++) if (o != t) pulse(o);
            repeat (10) @(negedge clk);
            chk(wr_n == 0, "R7 other trigger ignored", 32'(wr_n), 32'd0);
            pulse(t);
            wait_wr(2);
            chk(wr_n == 2, "R7 own trigger starts", 32'(wr_n), 32'd2);
            chk(irq_cnt[2] == 1, "R8 irq after triggered burst", 32'(irq_cnt[2]), 32'd1);
        end

        // R9: repeat with destination reload
        for (int dm = 3; dm >= 0; dm -= 3) begin
            clr();
            wr_reg(ra(1, 0), 32'h0000_6000);
            wr_reg(ra(1, 1), 32'h0000_7000);
            wr_reg(ra(1, 2), mk(1, 0, 2, 1, 1, 0, dm, 3));
            pulse(2);
            wait_wr(3);
            rd_reg(ra(1, 2), r);
            chk(r[31] == 1'b1, "R9 repeat keeps enable", 32'(r[31]), 32'd1);
            chk(wr_n == 3, "R9 first burst length", 32'(wr_n), 32'd3);
            pulse(2);
            wait_wr(6);
            chk(wr_n == 6, "R9 second burst length", 32'(wr_n), 32'd6);
            verify(3, 3, 32'h6000, 0, 3, 32'h7000, 0, (dm == 3) ? 0 : 3, 1'b1, "R9 second burst");
            wr_reg(ra(1, 2), 32'd0);
        end

        // R10: simultaneous pending, lowest channel first
        clr();
        wr_reg(ra(3, 0), 32'h0000_A000);
        wr_reg(ra(3, 1), 32'h0000_C000);
        wr_reg(ra(3, 2), mk(1, 0, 1, 1, 0, 0, 0, 3));
        wr_reg(ra(0, 0), 32'h0000_B000);
        wr_reg(ra(0, 1), 32'h0000_9000);
        wr_reg(ra(0, 2), mk(1, 0, 1, 1, 0, 0, 0, 3));
        pulse(1);
        wait_wr(6);
        verify(0, 3, 32'hB000, 0, 0, 32'h9000, 0, 0, 1'b1, "R10 channel 0 first");
        verify(3, 3, 32'hA000, 0, 0, 32'hC000, 0, 0, 1'b1, "R10 channel 3 after");

        // R10: higher channel takes over between units
        clr();
        wr_reg(ra(1, 0), 32'h0000_1100);
        wr_reg(ra(1, 1), 32'h0000_2200);
        wr_reg(ra(3, 0), 32'h0000_3300);
        wr_reg(ra(3, 1), 32'h0000_4400);
        wr_reg(ra(3, 2), mk(1, 0, 0, 1, 0, 0, 0, 4));
        wr_reg(ra(1, 2), mk(1, 0, 0, 1, 0, 0, 0, 2));
        wait_wr(6);
        chk(wr_n == 6, "R10 total units", 32'(wr_n), 32'd6);
        verify(0, 1, 32'h3300, 0, 0, 32'h4400, 0, 0, 1'b1, "R10 first unit");
        verify(1, 2, 32'h1100, 0, 0, 32'h2200, 0, 0, 1'b1, "R10 preempt");
        verify(3, 3, 32'h3300, 0, 1, 32'h4400, 0, 1, 1'b1, "R10 resume");

        finish_run();
    end

endmodule